// File: doc/BRIEF.md
# UART Modem-Line Flow Control Unit

This unit sits next to a single UART channel and takes over the modem handshake lines. It compares the receive FIFO fill level against a pair of programmable limits for each of the two outgoing lines, RTS# and DTR#. Each line goes high (deasserted) when the level climbs to its upper limit and returns low only once the level has drained to its lower limit. When automatic control is off, each line follows a software control bit and can serve as a plain output.

On the incoming side, CTS# passes through a two-flop synchronizer. Its state is reported as a modem-status bit, and a sticky change flag records every transition until the status is read. The transmitter asks for permission each time it wants to load its next character, so a character already on the wire is never cut short. When automatic CTS control is on, a deasserted CTS# refuses the request, except for in-band flow-control characters, which always go out. For half-duplex RS485 links, DTR# can instead be driven from the transmitter-empty flag, either direct or inverted, to steer the transceiver direction.

Top module: `uart_flow_ctrl`

## Requirements
- R1: With `auto_rts_en`=1, `rts_n` goes to 1 once `rx_level` >= `rts_thr_hi`. It returns to 0 only when `rx_level` <= `rts_thr_lo`, and it keeps its value while the level lies strictly between the two limits. Outputs settle within two clock edges of an input change.
- R2: With `auto_rts_en`=0, `rts_n` equals the inverse of `mcr_rts` (a 1 in the control bit drives the pin low).
- R3: With `auto_dtr_en`=1 and RS485 mode off, `dtr_n` follows the same hysteresis as R1, using `dtr_thr_hi`/`dtr_thr_lo`, independently of the RTS limits.
- R4: With `auto_dtr_en`=0 and RS485 mode off, `dtr_n` equals the inverse of `mcr_dtr`.
- R5: `rs485_mode[1]`=1 enables direction mode and `rs485_mode[0]` selects inversion. `dtr_n` then equals `tx_empty` when bit 0 is 0 and `~tx_empty` when bit 0 is 1. This overrides R3 and R4. Codes 2'b00 and 2'b01 leave direction mode off.
- R6: With `auto_cts_en`=1 and synchronized CTS# high, `tx_permit` is 0 during a load request. In every other case `tx_permit` equals `tx_load_req`.
- R7: A load request with `tx_next_is_fc`=1 is always granted, whatever the state of CTS#.
- R8: `tx_permit` is 0 whenever `tx_load_req` is 0.
- R9: `msr_cts` is the inverse of `cts_n` after a two-flop synchronizer, so it is valid two clock edges after `cts_n` changes.
- R10: A change in the synchronized CTS value sets `msr_dcts` on the following edge. A one-cycle `msr_read` clears it, and a set in the same cycle as a read wins over the clear.
- R11: If a lower limit is programmed at or above its upper limit, a level at or above the upper limit deasserts the line, and a level below the upper limit but at or below the lower limit reasserts it.
- R12: After reset, `rts_n` and `dtr_n` are 1 and `msr_cts` and `msr_dcts` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rts_thr_hi | input | LVL_W | RTS upper (deassert) limit |
| rts_thr_lo | input | LVL_W | RTS lower (reassert) limit |
| dtr_thr_hi | input | LVL_W | DTR upper limit |
| dtr_thr_lo | input | LVL_W | DTR lower limit |
| auto_rts_en | input | 1 | Automatic RTS control enable |
| auto_dtr_en | input | 1 | Automatic DTR control enable |
| mcr_rts | input | 1 | Manual RTS control bit (1 = assert) |
| mcr_dtr | input | 1 | Manual DTR control bit (1 = assert) |
| rs485_mode | input | 2 | [1] direction mode enable, [0] invert |
| tx_empty | input | 1 | Transmitter-empty flag |
| auto_cts_en | input | 1 | Automatic CTS gating enable |
| cts_n | input | 1 | Asynchronous active-low clear-to-send |
| tx_load_req | input | 1 | Transmitter asks to load next character |
| tx_next_is_fc | input | 1 | Next character is an in-band flow-control character |
| msr_read | input | 1 | Modem-status read strobe |
| tx_permit | output | 1 | Load granted |
| msr_cts | output | 1 | Synchronized CTS asserted |
| msr_dcts | output | 1 | Sticky CTS change flag |
| rts_n | output | 1 | Active-low request-to-send |
| dtr_n | output | 1 | Active-low data-terminal-ready or RS485 direction |

## Verification
The hardest case to reach from the ports is a status read that lands in the same cycle as a fresh CTS transition setting the change flag. In that cycle the set must win. The bench reaches it by counting the synchronizer edges: it toggles `cts_n`, waits exactly two rising edges, and raises `msr_read` for the one cycle in which the synchronized value differs from its delayed copy. It then checks that the flag stayed set, and that a later, separate read clears it. The misprogrammed limits of R11 are reached by writing a lower limit above the upper one and walking the level across both.

// File: rtl/flowctl_pkg.sv
// Package: shared constants for the flow control unit.
// Assumes: the direction-mode field is two bits, enable above invert.
package flowctl_pkg;
    localparam int DIR_EN_BIT  = 1;
    localparam int DIR_INV_BIT = 0;
    localparam int NUM_LINES   = 2;   // line 0 = RTS, line 1 = DTR
    localparam int LINE_RTS    = 0;
    localparam int LINE_DTR    = 1;
    typedef logic [1:0] dir_mode_t;
endpackage

// File: rtl/fc_hyst.sv
// Module: fc_hyst
// Two-limit hysteresis on a fill level. Sets 'halt' at or above the upper
// limit and clears it at or below the lower limit. Upper wins if both hold.
// Assumes: level and limits share one width; synchronous active-low reset.
module fc_hyst #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic [W-1:0] thr_hi,
    input  logic [W-1:0] thr_lo,
    output logic         halt
);
    // Purpose: hold the halt state, updating only when a limit is crossed.
    always_ff @(posedge clk) begin
        if (!rst_n)                halt <= 1'b0;
        else if (level >= thr_hi)  halt <= 1'b1;
        else if (level <= thr_lo)  halt <= 1'b0;
    end

    AST_HALT_AT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (level >= thr_hi) |=> halt);                                  // R1
    AST_RESUME_AT_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        (level < thr_hi && level <= thr_lo) |=> !halt);               // R11
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (level < thr_hi && level > thr_lo) |=> (halt == $past(halt))); // R1
endmodule

// File: rtl/fc_cts_gate.sv
// Module: fc_cts_gate
// Synchronizes CTS#, keeps a sticky change flag, and grants transmitter
// loads at character boundaries. Flow-control characters bypass the gate.
// Assumes: cts_n is asynchronous; msr_read is a single-cycle strobe.
module fc_cts_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_n,
    input  logic auto_cts_en,
    input  logic tx_load_req,
    input  logic tx_next_is_fc,
    input  logic msr_read,
    output logic tx_permit,
    output logic msr_cts,
    output logic msr_dcts
);
    logic meta_q, sync_q, prev_q;
    logic cts_change;

    // Purpose: two-flop synchronizer plus one delayed copy for edge detect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= cts_n;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign cts_change = sync_q ^ prev_q;

    // Purpose: sticky change flag; a new change beats a read clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          msr_dcts <= 1'b0;
        else if (cts_change) msr_dcts <= 1'b1;
        else if (msr_read)   msr_dcts <= 1'b0;
    end

    // Purpose: grant a load unless auto gating blocks a normal character.
    always_comb begin
        tx_permit = tx_load_req & (!auto_cts_en | !sync_q | tx_next_is_fc);
    end

    assign msr_cts = !sync_q;

    AST_NO_GRANT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_load_req |-> !tx_permit);                                 // R8
    AST_FC_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load_req && tx_next_is_fc) |-> tx_permit);                // R7
    AST_DCTS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(msr_cts) |=> msr_dcts);                              // R10
    AST_DCTS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_read && $stable(msr_cts) && msr_dcts) |=> !msr_dcts);    // R10
endmodule

// File: rtl/uart_flow_ctrl.sv
// Module: uart_flow_ctrl (top)
// Drives RTS# and DTR# from hysteresis, manual bits or RS485 direction,
// and gates transmitter loads on CTS#. DTR# priority: direction mode,
// then automatic control, then the manual bit.
// Assumes: one UART channel; outputs reset deasserted (high).
module uart_flow_ctrl
    import flowctl_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rts_thr_hi,
    input  logic [LVL_W-1:0] rts_thr_lo,
    input  logic [LVL_W-1:0] dtr_thr_hi,
    input  logic [LVL_W-1:0] dtr_thr_lo,
    input  logic             auto_rts_en,
    input  logic             auto_dtr_en,
    input  logic             mcr_rts,
    input  logic             mcr_dtr,
    input  logic [1:0]       rs485_mode,
    input  logic             tx_empty,
    input  logic             auto_cts_en,
    input  logic             cts_n,
    input  logic             tx_load_req,
    input  logic             tx_next_is_fc,
    input  logic             msr_read,
    output logic             tx_permit,
    output logic             msr_cts,
    output logic             msr_dcts,
    output logic             rts_n,
    output logic             dtr_n
);
    logic [NUM_LINES-1:0][LVL_W-1:0] thr_hi, thr_lo;
    logic [NUM_LINES-1:0]            halt;
    dir_mode_t                       dir_mode;

    assign thr_hi[LINE_RTS] = rts_thr_hi;
    assign thr_lo[LINE_RTS] = rts_thr_lo;
    assign thr_hi[LINE_DTR] = dtr_thr_hi;
    assign thr_lo[LINE_DTR] = dtr_thr_lo;
    assign dir_mode         = rs485_mode;

    // One hysteresis tracker per outgoing handshake line.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        fc_hyst #(.W(LVL_W)) i_hyst (
            .clk    (clk),
            .rst_n  (rst_n),
            .level  (rx_level),
            .thr_hi (thr_hi[g]),
            .thr_lo (thr_lo[g]),
            .halt   (halt[g])
        );
    end

    fc_cts_gate i_cts (
        .clk           (clk),
        .rst_n         (rst_n),
        .cts_n         (cts_n),
        .auto_cts_en   (auto_cts_en),
        .tx_load_req   (tx_load_req),
        .tx_next_is_fc (tx_next_is_fc),
        .msr_read      (msr_read),
        .tx_permit     (tx_permit),
        .msr_cts       (msr_cts),
        .msr_dcts      (msr_dcts)
    );

    // Purpose: register RTS# from auto hysteresis or the manual bit.
    always_ff @(posedge clk) begin
        if (!rst_n)           rts_n <= 1'b1;
        else if (auto_rts_en) rts_n <= halt[LINE_RTS];
        else                  rts_n <= !mcr_rts;
    end

    // Purpose: register DTR# with direction mode over auto over manual.
    always_ff @(posedge clk) begin
        if (!rst_n)                    dtr_n <= 1'b1;
        else if (dir_mode[DIR_EN_BIT]) dtr_n <= tx_empty ^ dir_mode[DIR_INV_BIT];
        else if (auto_dtr_en)          dtr_n <= halt[LINE_DTR];
        else                           dtr_n <= !mcr_dtr;
    end

    AST_RTS_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_rts_en |=> (rts_n == !$past(mcr_rts)));                 // R2
    AST_DTR_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_dtr_en && !rs485_mode[DIR_EN_BIT]) |=> (dtr_n == !$past(mcr_dtr))); // R4
    AST_DIR_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        rs485_mode[DIR_EN_BIT] |=> (dtr_n == ($past(tx_empty) ^ $past(rs485_mode[DIR_INV_BIT])))); // R5
endmodule

// File: tb/test_uart_flow_ctrl.sv
module test_uart_flow_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rx_level = '0, rts_thr_hi = 8'd100, rts_thr_lo = 8'd20;
    logic [7:0] dtr_thr_hi = 8'd60, dtr_thr_lo = 8'd30;
    logic       auto_rts_en = 0, auto_dtr_en = 0, mcr_rts = 0, mcr_dtr = 0;
    logic [1:0] rs485_mode = 2'b00;
    logic       tx_empty = 0, auto_cts_en = 0, cts_n = 1;
    logic       tx_load_req = 0, tx_next_is_fc = 0, msr_read = 0;
    logic       tx_permit, msr_cts, msr_dcts, rts_n, dtr_n;
    int         checks = 0, failures = 0;
    bit         done = 0;

    always #10 clk = ~clk;

    uart_flow_ctrl i_uart_flow_ctrl (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic t_reset;
        wait_clk(2);
        chk("R12 rts_n", rts_n, 1);
        chk("R12 dtr_n", dtr_n, 1);
        chk("R12 msr_cts", msr_cts, 0);
        chk("R12 msr_dcts", msr_dcts, 0);
        rst_n = 1'b1;
        wait_clk(3);
    endtask

    task automatic t_manual;
        mcr_rts = 1; mcr_dtr = 0; wait_clk(1);
        chk("R2 rts low", rts_n, 0);
        chk("R4 dtr high", dtr_n, 1);
        mcr_rts = 0; mcr_dtr = 1; wait_clk(1);
        chk("R2 rts high", rts_n, 1);
        chk("R4 dtr low", dtr_n, 0);
    endtask

    task automatic t_rts_auto;
        auto_rts_en = 1; rx_level = 50; wait_clk(3);
        chk("R1 below upper", rts_n, 0);
        rx_level = 100; wait_clk(3);
        chk("R1 at upper", rts_n, 1);
        rx_level = 50; wait_clk(3);
        chk("R1 hold between", rts_n, 1);
        rx_level = 21; wait_clk(3);
        chk("R1 just above lower", rts_n, 1);
        rx_level = 20; wait_clk(3);
        chk("R1 at lower", rts_n, 0);
        rx_level = 99; wait_clk(3);
        chk("R1 rising hold", rts_n, 0);
    endtask

    task automatic t_dtr_auto;
        auto_dtr_en = 1; rx_level = 60; wait_clk(3);
        chk("R3 dtr at own upper", dtr_n, 1);
        chk("R3 rts independent", rts_n, 0);
        rx_level = 31; wait_clk(3);
        chk("R3 dtr hold", dtr_n, 1);
        rx_level = 30; wait_clk(3);
        chk("R3 dtr at own lower", dtr_n, 0);
    endtask

    task automatic t_inverted_thr;
        rts_thr_hi = 10; rts_thr_lo = 40; rx_level = 30; wait_clk(3);
        chk("R11 upper wins", rts_n, 1);
        rx_level = 5; wait_clk(3);
        chk("R11 reassert", rts_n, 0);
        rx_level = 10; wait_clk(3);
        chk("R11 at upper", rts_n, 1);
        rts_thr_hi = 100; rts_thr_lo = 20;
    endtask

    task automatic t_rs485;
        mcr_dtr = 1; rx_level = 0;
        rs485_mode = 2'b10; tx_empty = 1; wait_clk(2);
        chk("R5 direct empty", dtr_n, 1);
        tx_empty = 0; wait_clk(2);
        chk("R5 direct busy", dtr_n, 0);
        rs485_mode = 2'b11; wait_clk(2);
        chk("R5 inverted busy", dtr_n, 1);
        rs485_mode = 2'b01; wait_clk(2);
        chk("R5 code 01 off", dtr_n, 0);
        rs485_mode = 2'b00;
    endtask

    task automatic t_cts_gate;
        auto_cts_en = 1; cts_n = 1; tx_load_req = 0; wait_clk(3);
        chk("R8 no request", tx_permit, 0);
        tx_load_req = 1; #1;
        chk("R6 blocked", tx_permit, 0);
        tx_next_is_fc = 1; #1;
        chk("R7 fc bypass", tx_permit, 1);
        tx_next_is_fc = 0; cts_n = 0; wait_clk(3);
        chk("R6 cts asserted", tx_permit, 1);
        cts_n = 1; auto_cts_en = 0; wait_clk(3);
        chk("R6 gating off", tx_permit, 1);
        tx_load_req = 0; #1;
        chk("R8 idle", tx_permit, 0);
    endtask

    task automatic t_msr;
        msr_read = 1; wait_clk(1); msr_read = 0; wait_clk(1);
        chk("R10 cleared", msr_dcts, 0);
        cts_n = 0; wait_clk(1);
        chk("R9 one edge", msr_cts, 0);
        wait_clk(1);
        chk("R9 two edges", msr_cts, 1);
        msr_read = 1; wait_clk(1); msr_read = 0;
        chk("R10 set wins", msr_dcts, 1);
        wait_clk(1);
        msr_read = 1; wait_clk(1); msr_read = 0;
        chk("R10 read clears", msr_dcts, 0);
        cts_n = 1; wait_clk(3);
        chk("R10 set on release", msr_dcts, 1);
        chk("R9 released", msr_cts, 0);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_manual();
        t_rts_auto();
        t_dtr_auto();
        t_inverted_thr();
        t_rs485();
        t_cts_gate();
        t_msr();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule